// File: doc/BRIEF.md
# Channel Fault Status Capture

This block gathers per-channel fault indications into a status word that a serial shifter loads at the start of each frame. Each channel has two raw inputs. A hard-fault input, such as overcurrent or overtemperature, is taken as soon as it is sampled. An open-load input is filtered first: it is only looked at while that channel is commanded off, and it becomes a fault only after it has lasted a set number of consecutive clock cycles.

The status word is frozen for the whole time chip select is low, so the bits being shifted out cannot change under the shifter. A fault that appears during a frame is held in a pending set and is not lost. When chip select rises, the word is rebuilt: a bit stays set only if its condition is still present or if it was raised during the frame that just ended. A bit that has been reported and whose cause has gone away is cleared at that point. While chip select is high, bits are sticky.

All inputs are synchronous to `clk`. Chip select is assumed to be synchronised to `clk` already.

Top module: `fault_status_capture`

## Requirements
- R1: While reset is asserted and right after it, `fault_status` is all zeros.
- R2: A high `raw_short[i]` sampled while `cs_n` is high sets bit i of `fault_status` at that same clock edge.
- R3: An open-load condition that lasts fewer than `DGL_CYCLES` consecutive sampled cycles never sets its fault bit.
- R4: An open-load condition on a channel that is off sets bit i exactly one edge after it has been sampled for `DGL_CYCLES` consecutive edges. With `DGL_CYCLES=5`, the bit is 0 after 5 edges and 1 after 6.
- R5: `raw_open[i]` has no effect while `chan_on[i]` is high, however long it lasts.
- R6: While `cs_n` is sampled low, `fault_status` does not change.
- R7: A fault raised while `cs_n` is low shows in `fault_status` at the edge where `cs_n` is first sampled high again, even if its cause is already gone.
- R8: While `cs_n` stays high, a set bit of `fault_status` never clears.
- R9: At the edge where `cs_n` is first sampled high after a frame, a bit whose condition is absent and which was not raised during the frame clears. A bit whose condition is still present stays set.
- R10: Turning a channel on during an open-load count discards the count, so the full `DGL_CYCLES` must elapse again once the channel is off.
- R11: Channels are independent: a fault on one channel sets no other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, already synchronous to clk |
| chan_on | input | NUM_CH | Commanded on/off state of each channel (1 = on) |
| raw_short | input | NUM_CH | Immediate hard-fault indication per channel |
| raw_open | input | NUM_CH | Unfiltered open-load indication per channel |
| fault_status | output | NUM_CH | Captured fault word, 1 = channel faulted |

## Verification
Hard faults are applied as a sequence of bit patterns: single channels, neighbouring pairs, and the full word. These show whether bits accumulate independently and stay sticky between frames. Open-load pulses are applied one cycle shorter than the filter window, exactly as long as the window, and with a switch-on in the middle of a count. These separate an off-by-one filter, a filter that never resets, and one that ignores the channel state. Frames are then run with faults that appear and disappear inside the frame, and with faults that persist across the rising chip-select edge. These show the freeze, the pending merge, and the conditional clear.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

   // Capture window state as seen from chip select.
   typedef enum logic {
      WIN_OPEN   = 1'b0,
      WIN_FROZEN = 1'b1
   } win_state_e;

   // Counter width wide enough to hold the value lim.
   function automatic int unsigned cnt_width(input int unsigned lim);
      int unsigned w;
      w = 1;
      while ((1 << w) <= lim) w++;
      return w;
   endfunction

endpackage

// File: rtl/fsc_open_filter.sv
module fsc_open_filter #(
   parameter int unsigned DGL_CYCLES = 16,
   parameter bit          FILTER_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_open,
   input  logic chan_on,
   output logic open_qual
);

   if (FILTER_EN) begin : g_filter
      localparam int unsigned CNT_W = fsc_pkg::cnt_width(DGL_CYCLES);
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DGL_CYCLES);

      logic [CNT_W-1:0] run_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_cnt <= '0;
         end else if (!raw_open || chan_on) begin
            run_cnt <= '0;
         end else if (run_cnt != LIMIT) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end

      assign open_qual = (run_cnt == LIMIT);
   end else begin : g_direct
      assign open_qual = raw_open & ~chan_on;
   end

endmodule

// File: rtl/fsc_window_ctl.sv
module fsc_window_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   output logic frozen,
   output logic reopen
);
   import fsc_pkg::*;

   win_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WIN_OPEN;
      end else begin
         state_q <= cs_n ? WIN_OPEN : WIN_FROZEN;
      end
   end

   assign frozen = ~cs_n;
   assign reopen = cs_n && (state_q == WIN_FROZEN);

endmodule

// File: rtl/fsc_capture_reg.sv
module fsc_capture_reg #(
   parameter int unsigned NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cond,
   input  logic              frozen,
   input  logic              reopen,
   output logic [NUM_CH-1:0] status
);

   logic [NUM_CH-1:0] status_q;
   logic [NUM_CH-1:0] pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q  <= '0;
         pending_q <= '0;
      end else if (frozen) begin
         pending_q <= pending_q | cond;
      end else if (reopen) begin
         status_q  <= cond | pending_q;
         pending_q <= '0;
      end else begin
         status_q  <= status_q | cond;
      end
   end

   assign status = status_q;

endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture #(
   parameter int unsigned NUM_CH     = 6,
   parameter int unsigned DGL_CYCLES = 16,
   parameter bit          FILTER_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic [NUM_CH-1:0] chan_on,
   input  logic [NUM_CH-1:0] raw_short,
   input  logic [NUM_CH-1:0] raw_open,
   output logic [NUM_CH-1:0] fault_status
);

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("fault_status_capture: NUM_CH must be 1..32");
   end
   if (DGL_CYCLES < 1) begin : g_bad_dgl
      $error("fault_status_capture: DGL_CYCLES must be at least 1");
   end

   logic [NUM_CH-1:0] open_qual;
   logic [NUM_CH-1:0] cond;
   logic              frozen;
   logic              reopen;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      fsc_open_filter #(
         .DGL_CYCLES (DGL_CYCLES),
         .FILTER_EN  (FILTER_EN)
      ) u_filt (
         .clk       (clk),
         .rst_n     (rst_n),
         .raw_open  (raw_open[ch]),
         .chan_on   (chan_on[ch]),
         .open_qual (open_qual[ch])
      );
   end

   assign cond = raw_short | open_qual;

   fsc_window_ctl u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .frozen (frozen),
      .reopen (reopen)
   );

   fsc_capture_reg #(
      .NUM_CH (NUM_CH)
   ) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond   (cond),
      .frozen (frozen),
      .reopen (reopen),
      .status (fault_status)
   );

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
   parameter int unsigned NUM_CH = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic [NUM_CH-1:0] raw_short,
   input logic [NUM_CH-1:0] fault_status
);

   logic cs_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_seen <= 1'b1;
      else        cs_seen <= cs_n;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (fault_status == '0)); // R1

   AST_SHORT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && (raw_short != '0)) |=>
         ((fault_status & $past(raw_short)) == $past(raw_short))); // R2

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |=> $stable(fault_status)); // R6

   AST_STICKY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && cs_seen) |=>
         ((fault_status & $past(fault_status)) == $past(fault_status))); // R8

endmodule

bind fault_status_capture fsc_checker #(
   .NUM_CH (NUM_CH)
) u_fsc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n         (cs_n),
   .raw_short    (raw_short),
   .fault_status (fault_status)
);

// File: tb/fault_status_capture_tb_top.sv
module fault_status_capture_tb_top;

   localparam int unsigned NCH = 6;
   localparam int unsigned DGL = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b1;
   logic           cs_n = 1'b1;
   logic [NCH-1:0] chan_on = '0;
   logic [NCH-1:0] raw_short = '0;
   logic [NCH-1:0] raw_open = '0;
   logic [NCH-1:0] fault_status;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fault_status_capture #(
      .NUM_CH     (NCH),
      .DGL_CYCLES (DGL),
      .FILTER_EN  (1'b1)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n         (cs_n),
      .chan_on      (chan_on),
      .raw_short    (raw_short),
      .raw_open     (raw_open),
      .fault_status (fault_status)
   );

   localparam logic [NCH-1:0] SHORT_TBL [6] = '{
      6'b000001, 6'b000100, 6'b100000, 6'b011000, 6'b000010, 6'b111111
   };

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic check(input string req, input logic [NCH-1:0] exp);
      checks++;
      if (fault_status !== exp) begin
         failures++;
         $display("FAIL %s: fault_status=%b expected=%b", req, fault_status, exp);
      end
   endtask

   task automatic frame(input int len);
      cs_n = 1'b0;
      tick(len);
      cs_n = 1'b1;
      tick(1);
   endtask

   initial begin
      #20000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [NCH-1:0] acc;
      #1 rst_n = 1'b0;
      tick(2);
      check("R1 in reset", '0);
      rst_n = 1'b1;
      tick(1);
      check("R1 after reset", '0);

      // R2 R8 R11: table of hard-fault patterns, accumulated while cs high
      acc = '0;
      for (int i = 0; i < 6; i++) begin
         raw_short = SHORT_TBL[i];
         tick(1);
         acc = acc | SHORT_TBL[i];
         check("R2 R11 capture", acc);
         raw_short = '0;
         tick(2);
         check("R8 sticky", acc);
      end
      frame(3);
      check("R9 clear at reopen", '0);

      // R3: open load one cycle short of the window
      raw_open = 6'b000100;
      tick(DGL - 1);
      raw_open = '0;
      tick(3);
      check("R3 short open ignored", '0);

      // R4: exact window timing
      raw_open = 6'b000100;
      tick(DGL);
      check("R4 not yet set", '0);
      tick(1);
      check("R4 set after window", 6'b000100);
      raw_open = '0;
      tick(1);
      frame(2);
      check("R9 open cleared", '0);

      // R10: switch-on mid count restarts the window
      raw_open = 6'b001000;
      tick(DGL - 1);
      chan_on = 6'b001000;
      tick(1);
      chan_on = '0;
      tick(DGL - 1);
      check("R10 count discarded", '0);
      tick(2);
      check("R10 set after fresh window", 6'b001000);
      raw_open = '0;
      tick(1);
      frame(2);
      check("R10 cleanup", '0);

      // R5: channel on, long open condition
      chan_on = 6'b010000;
      raw_open = 6'b010000;
      tick(4 * DGL);
      check("R5 open ignored while on", '0);
      raw_open = '0;
      chan_on = '0;
      tick(1);

      // R6 R7: fault raised and gone inside the frame
      cs_n = 1'b0;
      tick(1);
      raw_short = 6'b000010;
      tick(1);
      raw_short = '0;
      tick(2);
      check("R6 frozen during frame", '0);
      cs_n = 1'b1;
      tick(1);
      check("R7 pending merged at reopen", 6'b000010);
      frame(2);
      check("R9 reported bit cleared", '0);

      // R6 R9: set bit, persisting condition across frame
      raw_short = 6'b100000;
      tick(1);
      check("R2 set ch5", 6'b100000);
      cs_n = 1'b0;
      tick(3);
      check("R6 held during frame", 6'b100000);
      cs_n = 1'b1;
      tick(1);
      check("R9 persistent bit kept", 6'b100000);
      raw_short = '0;
      tick(1);
      frame(2);
      check("R9 cleared once gone", '0);

      // R3 R6: open load qualifying only inside a frame still gets reported
      cs_n = 1'b0;
      raw_open = 6'b000001;
      tick(DGL + 1);
      raw_open = '0;
      tick(1);
      check("R6 frozen vs open fault", '0);
      cs_n = 1'b1;
      tick(1);
      check("R7 open fault pending", 6'b000001);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule